// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt requests and presents one vectored request to a processor core. The five requests are two active-low external pins, two timer overflow flags and a serial flag. The serial flag is the OR of a receive flag and a transmit flag. A master enable and a per-source enable gate every request. A per-source priority bit places each source at one of two levels. A level register for each external pin chooses between level detection and falling-edge detection.

The core sees a registered request with a fixed 16-bit vector address. It takes the interrupt by pulsing `irq_ack` while `irq_req` is high. The controller then records the level now in service. For an edge-triggered pin, it also drops the latched edge. A `irq_reti` pulse ends the handler at the highest level in service.

Software reaches three 8-bit registers through a simple write strobe and a select code. Reads return one cycle after the select is applied.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Select code 0 addresses the enable register. Bit 7 is the master enable, and bits 0..4 enable, in order, external 0, timer 0, external 1, timer 1 and serial. Bits 5 and 6 always read 0, and writes to them have no effect.
- R2: While the master enable bit is 0, `irq_req` stays low whatever the per-source bits hold.
- R3: While the master enable bit is 1, a source raises `irq_req` only if its own enable bit is 1.
- R4: The vector is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial.
- R5: The serial source requests when `ser_rx` or `ser_tx` (or both) is high, and both use the serial vector.
- R6: Select code 1 addresses the trigger register. Bit 0 applies to external 0 and bit 1 to external 1. Value 0 means level mode: the request follows the sampled low pin, and it drops when the pin returns high.
- R7: A trigger bit of 1 selects edge mode. A high-to-low change between two samples latches a request that survives the pin going high again. An acknowledge of that source clears the latch.
- R8: Among requests at one priority level, the lowest index wins, in the order external 0, timer 0, external 1, timer 1, serial.
- R9: Select code 2 addresses the priority register. Bit i set to 1 makes source i high priority, using the R1 bit order. A high-priority request may interrupt a low-priority handler. While a high-priority handler runs, no request is presented. While a low-priority handler runs, low-priority requests wait.
- R10: A `irq_reti` pulse ends the high-level handler if one is in service, otherwise the low-level handler.
- R11: When `irq_ack` is high together with `irq_req` at a clock edge, `irq_req` is low in the following cycle.
- R12: After reset, `irq_req` is low and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External interrupt pins, active low (bit 0 = external 0) |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 = timer 0) |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 trigger, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the select code of the previous cycle |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | Core takes the presented request |
| irq_reti | input | 1 | Core returns from the handler in service |

## Verification
The assertions assume the following of the core. It pulses `irq_ack` only while `irq_req` is high. It pulses `irq_reti` only while a handler is in service, and never in the same cycle as `irq_ack`. The stimulus keeps to this: it acknowledges only when its own model expects a request, and it issues a return only when the model holds an active level. Before changing a pin, the stimulus writes the trigger register, so that a falling pin in edge mode arises only where a directed case intends it.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NSRC = 5;
  localparam int unsigned NEXT = 2;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_TRIG = 2'd1,
    SEL_PRIO = 2'd2
  } regsel_e;

  // fixed source order, also the same-level ranking
  localparam int unsigned IDX_EXT0 = 0;
  localparam int unsigned IDX_TMR0 = 1;
  localparam int unsigned IDX_EXT1 = 2;
  localparam int unsigned IDX_TMR1 = 3;
  localparam int unsigned IDX_SER  = 4;
endpackage

// File: rtl/vic_ext_trig.sv
module vic_ext_trig (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic smp_now, smp_old, edge_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now   <= 1'b1;
      smp_old   <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      smp_now <= pin_n;
      smp_old <= smp_now;
      // a fresh edge wins over a clear in the same cycle
      if (edge_mode && smp_old && !smp_now) edge_flag <= 1'b1;
      else if (clr)                         edge_flag <= 1'b0;
    end
  end

  assign req = edge_mode ? edge_flag : ~smp_now;
endmodule

// File: rtl/vic_src_pick.sv
module vic_src_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  hi_cand,
  input  logic [N-1:0]  lo_cand,
  output logic          valid,
  output logic          is_hi,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = (|hi_cand) | (|lo_cand);
    is_hi = |hi_cand;
    idx   = '0;
    // scan downward so the lowest index is the last one kept
    for (int i = N - 1; i >= 0; i--) begin
      if (is_hi ? hi_cand[i] : lo_cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned     DW         = 8,
  parameter int unsigned     AW         = 16,
  parameter logic [AW-1:0]   VEC_BASE   = 16'h0003,
  parameter int unsigned     VEC_STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ext_n,
  input  logic [1:0]    tmr_ovf,
  input  logic          ser_rx,
  input  logic          ser_tx,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_req,
  output logic [AW-1:0] irq_vec,
  input  logic          irq_ack,
  input  logic          irq_reti
);
  localparam int unsigned IW = $clog2(NSRC);
  localparam int unsigned GB = DW - 1;
  localparam logic [DW-1:0] EN_MASK = DW'((1 << GB) | ((1 << NSRC) - 1));

  logic [DW-1:0]   ie_q;
  logic [NEXT-1:0] trig_q;
  logic [NSRC-1:0] prio_q;
  logic            act_hi_q, act_lo_q;
  logic            req_q, sel_hi_q;
  logic [IW-1:0]   sel_idx_q;
  logic [AW-1:0]   vec_q;

  logic [NEXT-1:0] ext_req, ext_clr;
  logic [NSRC-1:0] raw, gated, hi_cand, lo_cand;
  logic            pk_valid, pk_hi, take;
  logic [IW-1:0]   pk_idx;

  assign take = irq_ack & req_q;

  // external pin front ends
  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    localparam int unsigned SLOT = (g == 0) ? IDX_EXT0 : IDX_EXT1;
    assign ext_clr[g] = take && (sel_idx_q == IW'(SLOT));
    vic_ext_trig u_trig (
      .clk       (clk),
      .rst       (rst),
      .pin_n     (ext_n[g]),
      .edge_mode (trig_q[g]),
      .clr       (ext_clr[g]),
      .req       (ext_req[g])
    );
  end

  always_comb begin
    raw           = '0;
    raw[IDX_EXT0] = ext_req[0];
    raw[IDX_TMR0] = tmr_ovf[0];
    raw[IDX_EXT1] = ext_req[1];
    raw[IDX_TMR1] = tmr_ovf[1];
    raw[IDX_SER]  = ser_rx | ser_tx;
    gated   = raw & ie_q[NSRC-1:0] & {NSRC{ie_q[GB]}};
    hi_cand = act_hi_q              ? '0 : (gated & prio_q);
    lo_cand = (act_hi_q | act_lo_q) ? '0 : (gated & ~prio_q);
  end

  vic_src_pick #(.N(NSRC), .IW(IW)) u_pick (
    .hi_cand (hi_cand),
    .lo_cand (lo_cand),
    .valid   (pk_valid),
    .is_hi   (pk_hi),
    .idx     (pk_idx)
  );

  // software registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= '0;
      trig_q    <= '0;
      prio_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          SEL_EN:   ie_q   <= reg_wdata & EN_MASK;
          SEL_TRIG: trig_q <= reg_wdata[NEXT-1:0];
          SEL_PRIO: prio_q <= reg_wdata[NSRC-1:0];
          default:  ;
        endcase
      end
      case (reg_sel)
        SEL_EN:   reg_rdata <= ie_q;
        SEL_TRIG: reg_rdata <= DW'(trig_q);
        SEL_PRIO: reg_rdata <= DW'(prio_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // request presentation and nesting state
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      sel_idx_q <= '0;
      sel_hi_q  <= 1'b0;
      act_hi_q  <= 1'b0;
      act_lo_q  <= 1'b0;
    end else begin
      req_q <= pk_valid & ~take;
      if (pk_valid) begin
        vec_q     <= VEC_BASE + AW'(pk_idx) * AW'(VEC_STRIDE);
        sel_idx_q <= pk_idx;
        sel_hi_q  <= pk_hi;
      end
      if (irq_reti) begin
        if (act_hi_q) act_hi_q <= 1'b0;
        else          act_lo_q <= 1'b0;
      end
      if (take) begin
        if (sel_hi_q) act_hi_q <= 1'b1;
        else          act_lo_q <= 1'b1;
      end
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [15:0] irq_vec,
  input logic [7:0]  reg_rdata,
  input logic        glb_en,
  input logic        act_hi
);
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req);                                  // R11

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_req);                                               // R2

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h000B ||
                 irq_vec == 16'h0013 || irq_vec == 16'h001B ||
                 irq_vec == 16'h0023));                                  // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[6:5] == 2'b00);                                            // R1

  AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    act_hi |=> !irq_req);                                                // R9
endmodule

bind vec_irq_ctrl vic_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .irq_vec   (irq_vec),
  .reg_rdata (reg_rdata),
  .glb_en    (ie_q[7]),
  .act_hi    (act_hi_q)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0, irq_reti = 1'b0;

  int n_run = 0, n_fail = 0;

  // bench model state
  logic [7:0] m_ie = 0;
  logic [1:0] m_trig = 0, m_flag = 0;
  logic [4:0] m_prio = 0;
  logic       m_ahi = 0, m_alo = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  function automatic int exp_idx();
    logic [4:0] raw, g, hc, lc;
    raw[0] = m_trig[0] ? m_flag[0] : ~ext_n[0];
    raw[1] = tmr_ovf[0];
    raw[2] = m_trig[1] ? m_flag[1] : ~ext_n[1];
    raw[3] = tmr_ovf[1];
    raw[4] = ser_rx | ser_tx;
    g  = m_ie[7] ? (raw & m_ie[4:0]) : 5'd0;
    hc = m_ahi ? 5'd0 : (g & m_prio);
    lc = (m_ahi | m_alo) ? 5'd0 : (g & ~m_prio);
    for (int i = 0; i < 5; i++) if (hc[i]) return i;
    for (int i = 0; i < 5; i++) if (lc[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] vec_of(input int i);
    return 16'h0003 + 16'(i * 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    int e;
    e = exp_idx();
    if (e < 0) chk(tag, {31'd0, irq_req}, 32'd0);
    else chk(tag, {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, vec_of(e)});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      2'd0: m_ie = d & 8'h9F;
      2'd1: m_trig = d[1:0];
      2'd2: m_prio = d[4:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // takes the presented request; checks R11 one cycle later
  task automatic ack_it(input string tag);
    int e;
    e = exp_idx();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk({tag, " R11 req drops after ack"}, {31'd0, irq_req}, 32'd0);
    if (e >= 0) begin
      if (m_prio[e]) m_ahi = 1'b1; else m_alo = 1'b1;
      if (e == 0) m_flag[0] = 1'b0;
      if (e == 2) m_flag[1] = 1'b0;
    end
  endtask

  task automatic reti_it();
    @(negedge clk);
    irq_reti = 1'b1;
    @(negedge clk);
    irq_reti = 1'b0;
    if (m_ahi) m_ahi = 1'b0; else m_alo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 req after reset", {31'd0, irq_req}, 32'd0);
    rd(2'd0, d); chk("R12 enable reg", {24'd0, d}, 32'h00);
    rd(2'd1, d); chk("R12 trigger reg", {24'd0, d}, 32'h00);
    rd(2'd2, d); chk("R12 priority reg", {24'd0, d}, 32'h00);

    // R1 reserved bits ignored
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R1 enable readback", {24'd0, d}, 32'h9F);
    wr(2'd0, 8'h60); rd(2'd0, d); chk("R1 reserved only", {24'd0, d}, 32'h00);

    // R2 master off
    tmr_ovf = 2'b01;
    wr(2'd0, 8'h1F); settle();
    chk("R2 master off", {31'd0, irq_req}, 32'd0);
    wr(2'd0, 8'h9F); settle(); check_out("R2 master on");
    chk("R4 timer0 vector", {16'd0, irq_vec}, 32'h000B);

    // R3 per-source gate
    tmr_ovf = 2'b11;
    wr(2'd0, 8'h88); settle(); check_out("R3 only timer1 enabled");
    chk("R3 timer1 vector", {16'd0, irq_vec}, 32'h001B);
    wr(2'd0, 8'h80); settle();
    chk("R3 none enabled", {31'd0, irq_req}, 32'd0);
    tmr_ovf = 2'b00;

    // R5 serial OR
    wr(2'd0, 8'h90);
    ser_rx = 1'b1; settle(); chk("R5 rx vector", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0023});
    ser_rx = 1'b0; ser_tx = 1'b1; settle(); chk("R5 tx vector", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0023});
    ser_tx = 1'b0; settle(); chk("R5 neither", {31'd0, irq_req}, 32'd0);

    // R8 / R4 ordering: everything asserted, peel off enables
    ext_n = 2'b00; tmr_ovf = 2'b11; ser_rx = 1'b1;
    wr(2'd0, 8'h9F); settle(); chk("R8 ext0 first", {16'd0, irq_vec}, 32'h0003);
    wr(2'd0, 8'h9E); settle(); chk("R8 timer0 next", {16'd0, irq_vec}, 32'h000B);
    wr(2'd0, 8'h9C); settle(); chk("R8 R4 ext1 vector", {16'd0, irq_vec}, 32'h0013);
    wr(2'd0, 8'h98); settle(); chk("R8 timer1 next", {16'd0, irq_vec}, 32'h001B);
    wr(2'd0, 8'h90); settle(); chk("R8 serial last", {16'd0, irq_vec}, 32'h0023);
    ext_n = 2'b11; tmr_ovf = 2'b00; ser_rx = 1'b0;

    // R6 level mode
    wr(2'd0, 8'h81);
    ext_n[0] = 1'b0; settle(); check_out("R6 level low requests");
    ext_n[0] = 1'b1; settle(); chk("R6 level no latch", {31'd0, irq_req}, 32'd0);

    // R7 edge mode on external 1
    wr(2'd1, 8'h02); wr(2'd0, 8'h84);
    ext_n[1] = 1'b0; repeat (3) @(negedge clk); ext_n[1] = 1'b1;
    m_flag[1] = 1'b1; settle();
    chk("R7 edge latched", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0013});
    ack_it("R7");
    reti_it(); settle();
    chk("R7 latch cleared by ack", {31'd0, irq_req}, 32'd0);
    wr(2'd1, 8'h00);

    // R9 / R10 nesting: timer1 low, timer0 and ext0 high
    wr(2'd2, 8'h03); wr(2'd0, 8'h88);
    tmr_ovf = 2'b10; settle(); check_out("R9 low request");
    ack_it("R9 low");
    wr(2'd0, 8'h8A); tmr_ovf = 2'b11; settle();
    chk("R9 high preempts low", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h000B});
    ack_it("R9 high");
    wr(2'd0, 8'h8B); ext_n[0] = 1'b0; settle();
    chk("R9 high blocks high", {31'd0, irq_req}, 32'd0);
    reti_it(); settle();
    chk("R10 reti ends high level", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0003});
    ext_n[0] = 1'b1; tmr_ovf = 2'b10; settle();
    chk("R9 low waits under low", {31'd0, irq_req}, 32'd0);
    reti_it(); settle();
    chk("R10 reti ends low level", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h001B});
    tmr_ovf = 2'b00;
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); settle();

    // random mix, model-checked
    for (int it = 0; it < 400; it++) begin
      logic [1:0] ty;
      ty = 2'($urandom);
      wr(2'd1, {6'd0, ty});
      if (($urandom % 4) == 0) wr(2'd0, 8'($urandom));
      if (($urandom % 4) == 0) wr(2'd2, 8'($urandom));
      @(negedge clk);
      ext_n[0] = ty[0] ? 1'b1 : 1'($urandom);
      ext_n[1] = ty[1] ? 1'b1 : 1'($urandom);
      tmr_ovf = 2'($urandom);
      ser_rx = 1'($urandom); ser_tx = 1'($urandom);
      settle();
      check_out("R3 R8 R9 random");
      if (exp_idx() >= 0 && ($urandom % 2) == 0) begin
        ack_it("random");
        settle(); check_out("R9 random after ack");
      end
      if ((m_ahi | m_alo) && ($urandom % 3) == 0) begin
        reti_it(); settle(); check_out("R10 random after reti");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule